// File: doc/BRIEF.md
# Expansion RAM DMA Controller

This block is a register-programmed byte mover that sits between an 8-bit host computer and a banked expansion RAM. Software fills a small byte-wide register window with a host base address, an expansion base address and bank, a 16-bit byte count, an interrupt mask and an address-step control. It then sets the execute bit in the control register. The engine holds the CPU ready line low while it copies bytes host-to-expansion (stash) or expansion-to-host (fetch), exchanges them (swap), or compares them (verify).

Each address and length register has two copies: a latched one that holds what software wrote, and a working one that the engine advances. When the autoload option is set, the working copies are reloaded from the latched ones at the end of a transfer, so the same block can be repeated without reprogramming. A transfer can also be deferred until the host writes to address 0xFF00. This lets software program the engine and then trigger it with a single store to that address.

Both memories are external. They are read combinationally from the address outputs and written on the clock edge when the matching write strobe is high.

Top module: `xdma_top`

## Requirements
- R1: After reset the control register (offset 0x1) reads 0x10, the length reads 0xFFFF at offsets 0x7 (low byte) and 0x8 (high byte), cpu_rdy is 1 and irq is 0.
- R2: A write to offset 0x7 or 0x8 replaces that byte of the latched length and loads the whole latched value into the working length, which is what reads return.
- R3: Mode 0 (control bits [1:0] = 0, stash) copies each host byte to the expansion RAM, one byte per cycle.
- R4: Mode 1 (fetch) copies each expansion byte to host memory, one byte per cycle.
- R5: Mode 2 (swap) exchanges host and expansion bytes and takes two cycles per byte.
- R6: Mode 3 (verify) compares bytes without writing. On the first mismatch it sets status (offset 0x0) bit 5 and ends the transfer after that byte.
- R7: Writing control with bit 7 = 1 and bit 4 = 0 leaves the transfer pending. A host write to an address other than 0xFF00 has no effect, and a host write to 0xFF00 starts the transfer.
- R8: Writing control with bits 7 and 4 both set starts the transfer at once. Starting a transfer clears control bit 7 and sets control bit 4.
- R9: The expansion address is {bank (offset 0x6), base (offsets 0x4 low, 0x5 high)} and the host address is offsets 0x2 (low) and 0x3 (high). Each advances by one per byte unless address control (offset 0xA) bit 7 holds the host side or bit 6 holds the expansion side.
- R10: After each byte the working length is decremented unless it is 1, in which case the transfer ends. A length of 0 therefore moves 65536 bytes.
- R11: After each byte, status bit 6 is 1 exactly when the working length has reached 1.
- R12: With control bit 5 (autoload) set, completion reloads the host base, expansion base, bank and length from their latched copies.
- R13: Status bit 7 (pending) and the irq output are set at completion when mask (offset 0x9) bits 7 and 6 are set, and on a verify fault when mask bits 7 and 5 are set. Reading the status register clears bit 7.
- R14: cpu_rdy goes low in the second cycle after the transfer starts. The first byte moves in the cycle after that, and cpu_rdy stays low until the last byte has moved, so a transfer of N bytes holds it low for N+1 cycles (2N+1 in swap mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_cs | input | 1 | Register window access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_wr | input | 1 | Host CPU store on its bus |
| cpu_waddr | input | 16 | Address of that host store |
| cpu_rdy | output | 1 | CPU ready; low while the engine owns the bus |
| irq | output | 1 | Interrupt request, mirrors status bit 7 |
| h_addr | output | 16 | Host memory address |
| h_rdata | input | 8 | Host memory read data |
| h_we | output | 1 | Host memory write strobe |
| h_wdata | output | 8 | Host memory write data |
| x_addr | output | BANKW+16 | Expansion RAM address {bank, base} |
| x_rdata | input | 8 | Expansion RAM read data |
| x_we | output | 1 | Expansion RAM write strobe |
| x_wdata | output | 8 | Expansion RAM write data |

## Verification
The following properties are checked on every cycle by assertions:
- Ready goes high and then low in the two cycles after a start.
- No memory is written while ready is high.
- Both memories are written together only in swap mode.
- A verify mismatch returns ready high on the next cycle.
- Starting a transfer clears the execute bit and sets the trigger-disable bit.
- The length steps down by one on each byte that is not the last.
- Autoload reloads the latched values.
- Reading the status register drops the pending flag.

The following behaviour is shown only by the bench's directed scenarios:
- The data actually moved, exchanged or compared at the right addresses.
- The hold bits in address control.
- The deferred start on a 0xFF00 store.
- The 65536-byte run for a zero length.
- The exact status byte left after each mode.

// File: rtl/xdma_pkg.sv
// Shared types and register layout for the expansion RAM DMA controller.
// Assumes 16-bit host addresses and a 16-bit length, each mapped as two bytes.
package xdma_pkg;
    localparam int HAW  = 16;
    localparam int LENW = 16;

    typedef enum logic [1:0] {
        MODE_STASH  = 2'd0,
        MODE_FETCH  = 2'd1,
        MODE_SWAP   = 2'd2,
        MODE_VERIFY = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PREP, ST_HOLD, ST_MOVE, ST_SWAPW
    } seq_state_e;

    localparam logic [3:0] OFS_STATUS = 4'h0;
    localparam logic [3:0] OFS_CTRL   = 4'h1;
    localparam logic [3:0] OFS_HLO    = 4'h2;
    localparam logic [3:0] OFS_HHI    = 4'h3;
    localparam logic [3:0] OFS_XLO    = 4'h4;
    localparam logic [3:0] OFS_XHI    = 4'h5;
    localparam logic [3:0] OFS_BANK   = 4'h6;
    localparam logic [3:0] OFS_LLO    = 4'h7;
    localparam logic [3:0] OFS_LHI    = 4'h8;
    localparam logic [3:0] OFS_IMASK  = 4'h9;
    localparam logic [3:0] OFS_ACTL   = 4'hA;

    localparam int CTL_EXEC   = 7;
    localparam int CTL_AUTO   = 5;
    localparam int CTL_NOTRIG = 4;
    localparam int IM_GLOBAL  = 7;
    localparam int IM_EOB     = 6;
    localparam int IM_FAULT   = 5;
    localparam int AC_HOLD_H  = 7;
    localparam int AC_HOLD_X  = 6;

    localparam logic [7:0] CTRL_RESET = 8'h10;
endpackage

// File: rtl/xdma_regfile.sv
// Register window of the DMA controller: control, mask, address control,
// latched and working copies of both addresses and the length, and status.
// Assumes the engine reports byte_done/mismatch/finish in the cycle a byte
// completes; bus accesses are not expected while the engine is busy.
module xdma_regfile
    import xdma_pkg::*;
#(
    parameter int BANKW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [3:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             idle,
    input  logic             trig_hit,
    input  logic             byte_done,
    input  logic             mismatch,
    input  logic             finish,
    output logic             arm,
    output logic             len_one,
    output xfer_mode_e       mode,
    output logic [HAW-1:0]   host_addr,
    output logic [BANKW+HAW-1:0] xp_addr,
    output logic             irq
);
    localparam int XAW = BANKW + HAW;

    logic [7:0]       ctrl_q, imask_q, actl_q;
    logic [HAW-1:0]   hl_q, hw_q, xl_q, xw_q;
    logic [BANKW-1:0] bl_q, bw_q;
    logic [LENW-1:0]  ll_q, len_q;
    logic [2:0]       stat_q;   // {pending, end-of-block, fault}
    logic             pend_set, rd_status, reload;
    logic [XAW-1:0]   xnext;

    function automatic logic hit(input logic [3:0] ofs);
        return bus_wr && (bus_addr == ofs);
    endfunction

    assign arm = idle && ((hit(OFS_CTRL) && bus_wdata[CTL_EXEC] && bus_wdata[CTL_NOTRIG])
               || (ctrl_q[CTL_EXEC] && !ctrl_q[CTL_NOTRIG] && trig_hit));
    assign len_one   = (len_q == LENW'(1));
    assign mode      = xfer_mode_e'(ctrl_q[1:0]);
    assign host_addr = hw_q;
    assign xp_addr   = {bw_q, xw_q};
    assign irq       = stat_q[2];
    assign reload    = finish && ctrl_q[CTL_AUTO];
    assign rd_status = bus_rd && (bus_addr == OFS_STATUS);
    assign xnext     = {bw_q, xw_q} + XAW'(1);
    assign pend_set  = imask_q[IM_GLOBAL] && ((mismatch && imask_q[IM_FAULT])
                                           || (finish && imask_q[IM_EOB]));

    // Control register: software writes, and the start rewrite of exec/notrig.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (arm) begin
            ctrl_q             <= hit(OFS_CTRL) ? bus_wdata : ctrl_q;
            ctrl_q[CTL_EXEC]   <= 1'b0;
            ctrl_q[CTL_NOTRIG] <= 1'b1;
        end else if (hit(OFS_CTRL)) begin
            ctrl_q <= bus_wdata;
        end
    end

    // Interrupt mask and address control: plain software registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask_q <= '0;
            actl_q  <= '0;
        end else begin
            if (hit(OFS_IMASK)) imask_q <= bus_wdata;
            if (hit(OFS_ACTL))  actl_q  <= bus_wdata;
        end
    end

    // Host base: latched copy plus working copy that steps per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hl_q <= '0;
            hw_q <= '0;
        end else if (hit(OFS_HLO)) begin
            hl_q <= {hl_q[15:8], bus_wdata};
            hw_q <= {hl_q[15:8], bus_wdata};
        end else if (hit(OFS_HHI)) begin
            hl_q <= {bus_wdata, hl_q[7:0]};
            hw_q <= {bus_wdata, hl_q[7:0]};
        end else if (reload) begin
            hw_q <= hl_q;
        end else if (byte_done && !actl_q[AC_HOLD_H]) begin
            hw_q <= hw_q + HAW'(1);
        end
    end

    // Expansion base and bank: latched copies plus working {bank, base}.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_q <= '0;
            xw_q <= '0;
            bl_q <= '0;
            bw_q <= '0;
        end else if (hit(OFS_XLO)) begin
            xl_q <= {xl_q[15:8], bus_wdata};
            xw_q <= {xl_q[15:8], bus_wdata};
        end else if (hit(OFS_XHI)) begin
            xl_q <= {bus_wdata, xl_q[7:0]};
            xw_q <= {bus_wdata, xl_q[7:0]};
        end else if (hit(OFS_BANK)) begin
            bl_q <= bus_wdata[BANKW-1:0];
            bw_q <= bus_wdata[BANKW-1:0];
        end else if (reload) begin
            xw_q <= xl_q;
            bw_q <= bl_q;
        end else if (byte_done && !actl_q[AC_HOLD_X]) begin
            {bw_q, xw_q} <= xnext;
        end
    end

    // Length: latched copy and working down-counter that stops at one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ll_q  <= '1;
            len_q <= '1;
        end else if (hit(OFS_LLO)) begin
            ll_q  <= {ll_q[15:8], bus_wdata};
            len_q <= {ll_q[15:8], bus_wdata};
        end else if (hit(OFS_LHI)) begin
            ll_q  <= {bus_wdata, ll_q[7:0]};
            len_q <= {bus_wdata, ll_q[7:0]};
        end else if (reload) begin
            len_q <= ll_q;
        end else if (byte_done && !len_one) begin
            len_q <= len_q - LENW'(1);
        end
    end

    // Status flags: fault, end-of-block and the read-cleared pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            if (arm)       stat_q[0] <= 1'b0;
            if (mismatch)  stat_q[0] <= 1'b1;
            if (byte_done) stat_q[1] <= len_one || (len_q == LENW'(2));
            if (pend_set)       stat_q[2] <= 1'b1;
            else if (rd_status) stat_q[2] <= 1'b0;
        end
    end

    // Read multiplexer over the working copies.
    always_comb begin
        case (bus_addr)
            OFS_STATUS: bus_rdata = {stat_q, 5'b0};
            OFS_CTRL:   bus_rdata = ctrl_q;
            OFS_HLO:    bus_rdata = hw_q[7:0];
            OFS_HHI:    bus_rdata = hw_q[15:8];
            OFS_XLO:    bus_rdata = xw_q[7:0];
            OFS_XHI:    bus_rdata = xw_q[15:8];
            OFS_BANK:   bus_rdata = 8'(bw_q);
            OFS_LLO:    bus_rdata = len_q[7:0];
            OFS_LHI:    bus_rdata = len_q[15:8];
            OFS_IMASK:  bus_rdata = imask_q;
            OFS_ACTL:   bus_rdata = actl_q;
            default:    bus_rdata = 8'h00;
        endcase
    end

    assert_exec_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!ctrl_q[CTL_EXEC] && ctrl_q[CTL_NOTRIG]));

    assert_len_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !finish && !bus_wr) |=> (len_q == $past(len_q) - LENW'(1)));

    assert_autoload_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !bus_wr) |=> (hw_q == hl_q && xw_q == xl_q && len_q == ll_q && bw_q == bl_q));

    assert_pend_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !pend_set) |=> !irq);
endmodule

// File: rtl/xdma_seq.sv
// Transfer sequencer: start delay, ready hold, per-byte moves for the four
// modes, and the end condition. Assumes both memories return read data in
// the same cycle as the address and write on the clock edge.
module xdma_seq
    import xdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  xfer_mode_e mode,
    input  logic       len_one,
    input  logic [7:0] h_rdata,
    input  logic [7:0] x_rdata,
    output logic       idle,
    output logic       cpu_rdy,
    output logic       byte_done,
    output logic       mismatch,
    output logic       finish,
    output logic       h_we,
    output logic [7:0] h_wdata,
    output logic       x_we,
    output logic [7:0] x_wdata
);
    seq_state_e state_q, state_d;
    logic [7:0] cap_h_q, cap_x_q;
    logic       moving;

    assign moving    = (state_q == ST_MOVE);
    assign idle      = (state_q == ST_IDLE);
    assign cpu_rdy   = (state_q == ST_IDLE) || (state_q == ST_PREP);
    assign byte_done = (moving && mode != MODE_SWAP) || (state_q == ST_SWAPW);
    assign mismatch  = moving && (mode == MODE_VERIFY) && (h_rdata != x_rdata);
    assign finish    = byte_done && (len_one || mismatch);
    assign h_we      = (moving && mode == MODE_FETCH) || (state_q == ST_SWAPW);
    assign x_we      = (moving && mode == MODE_STASH) || (state_q == ST_SWAPW);
    assign h_wdata   = (state_q == ST_SWAPW) ? cap_x_q : x_rdata;
    assign x_wdata   = (state_q == ST_SWAPW) ? cap_h_q : h_rdata;

    // Next-state selection for the start delay and the byte loop.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (arm) state_d = ST_PREP;
            ST_PREP:  state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_MOVE;
            ST_MOVE:  state_d = (mode == MODE_SWAP) ? ST_SWAPW : (finish ? ST_IDLE : ST_MOVE);
            ST_SWAPW: state_d = finish ? ST_IDLE : ST_MOVE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Swap capture: hold both bytes read in the first swap cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_h_q <= '0;
            cap_x_q <= '0;
        end else if (moving && mode == MODE_SWAP) begin
            cap_h_q <= h_rdata;
            cap_x_q <= x_rdata;
        end
    end

    assert_rdy_timing_R14: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> cpu_rdy ##1 !cpu_rdy);

    assert_no_write_ready_R14: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |-> (!h_we && !x_we));

    assert_dual_write_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && x_we) |-> (mode == MODE_SWAP));

    assert_verify_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> cpu_rdy);
endmodule

// File: rtl/xdma_top.sv
// Expansion RAM DMA controller top: joins the register window and the
// sequencer and detects the host store to the trigger address.
// Assumes the two memories are external synchronous-write arrays.
module xdma_top
    import xdma_pkg::*;
#(
    parameter int          BANKW     = 8,
    parameter logic [15:0] TRIG_ADDR = 16'hFF00,
    localparam int         XAW       = BANKW + HAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_cs,
    input  logic           reg_we,
    input  logic [3:0]     reg_addr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    input  logic           cpu_wr,
    input  logic [15:0]    cpu_waddr,
    output logic           cpu_rdy,
    output logic           irq,
    output logic [HAW-1:0] h_addr,
    input  logic [7:0]     h_rdata,
    output logic           h_we,
    output logic [7:0]     h_wdata,
    output logic [XAW-1:0] x_addr,
    input  logic [7:0]     x_rdata,
    output logic           x_we,
    output logic [7:0]     x_wdata
);
    logic       idle, arm, len_one, byte_done, mismatch, finish, trig_hit;
    xfer_mode_e mode;

    assign trig_hit = cpu_wr && (cpu_waddr == TRIG_ADDR);

    xdma_regfile #(.BANKW(BANKW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(reg_cs && reg_we), .bus_rd(reg_cs && !reg_we),
        .bus_addr(reg_addr), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
        .idle(idle), .trig_hit(trig_hit), .byte_done(byte_done),
        .mismatch(mismatch), .finish(finish), .arm(arm), .len_one(len_one),
        .mode(mode), .host_addr(h_addr), .xp_addr(x_addr), .irq(irq)
    );

    xdma_seq u_seq (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .len_one(len_one),
        .h_rdata(h_rdata), .x_rdata(x_rdata), .idle(idle), .cpu_rdy(cpu_rdy),
        .byte_done(byte_done), .mismatch(mismatch), .finish(finish),
        .h_we(h_we), .h_wdata(h_wdata), .x_we(x_we), .x_wdata(x_wdata)
    );
endmodule

// File: tb/xdma_top_tb.sv
// Directed bench for the expansion RAM DMA controller.
module xdma_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_cs = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_waddr = '0;
    logic        cpu_rdy, irq, h_we, x_we;
    logic [15:0] h_addr;
    logic [23:0] x_addr;
    logic [7:0]  h_rdata, h_wdata, x_rdata, x_wdata;
    logic [7:0]  hmem [1024];
    logic [7:0]  xmem [1024];
    int          n_chk = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;

    xdma_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_wr(cpu_wr), .cpu_waddr(cpu_waddr), .cpu_rdy(cpu_rdy), .irq(irq),
        .h_addr(h_addr), .h_rdata(h_rdata), .h_we(h_we), .h_wdata(h_wdata),
        .x_addr(x_addr), .x_rdata(x_rdata), .x_we(x_we), .x_wdata(x_wdata)
    );

    assign h_rdata = hmem[h_addr[9:0]];
    assign x_rdata = xmem[x_addr[9:0]];
    always @(posedge clk) begin
        if (h_we) hmem[h_addr[9:0]] <= h_wdata;
        if (x_we) xmem[x_addr[9:0]] <= x_wdata;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog act=%0d exp=<190000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_cs = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_cs = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 4'd1, hi);
        v = {hi, lo};
    endtask

    task automatic cpu_store(input logic [15:0] a);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_waddr = a;
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic setup(input logic [15:0] h, input logic [15:0] x, input logic [7:0] b,
                         input logic [15:0] len, input logic [7:0] ac, input logic [7:0] im);
        wr(4'h2, h[7:0]);   wr(4'h3, h[15:8]);
        wr(4'h4, x[7:0]);   wr(4'h5, x[15:8]);
        wr(4'h6, b);
        wr(4'h8, len[15:8]); wr(4'h7, len[7:0]);
        wr(4'hA, ac);        wr(4'h9, im);
    endtask

    // Count the cycles with cpu_rdy low; called at the negedge after the start edge.
    task automatic wait_done(output int lows, output logic [23:0] xa);
        lows = 0; xa = '0;
        @(negedge clk);
        while (!cpu_rdy && lows < 70000) begin
            if (lows == 0) xa = x_addr;
            lows++;
            @(negedge clk);
        end
    endtask

    task automatic run(input string req, input logic [7:0] c, output int lows, output logic [23:0] xa);
        wr(4'h1, c);
        chk({req, " R14 ready still high in first cycle after start"}, 32'(cpu_rdy), 32'd1);
        wait_done(lows, xa);
    endtask

    task automatic t_reset;
        logic [7:0] v; logic [15:0] l;
        chk("R1 cpu_rdy after reset", 32'(cpu_rdy), 32'd1);
        chk("R1 irq after reset", 32'(irq), 32'd0);
        rd(4'h1, v);  chk("R1 control reset value", 32'(v), 32'h10);
        rd16(4'h7, l); chk("R1 length reset value", 32'(l), 32'hFFFF);
    endtask

    task automatic t_stash;
        int lows; logic [23:0] xa; logic [15:0] v; logic [7:0] s;
        setup(16'h0010, 16'h0020, 8'h01, 16'd5, 8'h00, 8'h00);
        rd16(4'h7, v); chk("R2 length readback after byte writes", 32'(v), 32'd5);
        run("R3", 8'h90, lows, xa);
        chk("R14 stash ready-low cycles", lows, 6);
        chk("R9 expansion address is bank:base", 32'(xa), 32'h010020);
        for (int i = 0; i < 5; i++)
            chk("R3 stash byte", 32'(xmem[10'h20 + i]), 32'(hmem[10'h10 + i]));
        rd16(4'h2, v); chk("R9 host address advanced", 32'(v), 32'h0015);
        rd16(4'h4, v); chk("R9 expansion base advanced", 32'(v), 32'h0025);
        rd16(4'h7, v); chk("R10 length left at one", 32'(v), 32'd1);
        rd(4'h0, s);   chk("R11 end-of-block bit after stash", 32'(s), 32'h40);
        rd(4'h1, s);   chk("R8 control after immediate start", 32'(s), 32'h10);
    endtask

    task automatic t_fetch;
        int lows; logic [23:0] xa;
        setup(16'h0100, 16'h0040, 8'h00, 16'd3, 8'h00, 8'h00);
        run("R4", 8'h91, lows, xa);
        chk("R14 fetch ready-low cycles", lows, 4);
        for (int i = 0; i < 3; i++)
            chk("R4 fetch byte", 32'(hmem[10'h100 + i]), 32'(xmem[10'h40 + i]));
    endtask

    task automatic t_swap;
        int lows; logic [23:0] xa; logic [7:0] oh [3]; logic [7:0] ox [3];
        for (int i = 0; i < 3; i++) begin
            oh[i] = hmem[10'h200 + i]; ox[i] = xmem[10'h80 + i];
        end
        setup(16'h0200, 16'h0080, 8'h00, 16'd3, 8'h00, 8'h00);
        run("R5", 8'h92, lows, xa);
        chk("R5 swap takes two cycles per byte", lows, 7);
        for (int i = 0; i < 3; i++) begin
            chk("R5 swap host side", 32'(hmem[10'h200 + i]), 32'(ox[i]));
            chk("R5 swap expansion side", 32'(xmem[10'h80 + i]), 32'(oh[i]));
        end
    endtask

    task automatic t_verify;
        int lows; logic [23:0] xa; logic [7:0] s; logic [15:0] v;
        for (int i = 0; i < 4; i++) xmem[10'hC0 + i] = hmem[10'h300 + i];
        xmem[10'hC2] = ~hmem[10'h302];
        setup(16'h0300, 16'h00C0, 8'h00, 16'd4, 8'h00, 8'hA0);
        run("R6", 8'h93, lows, xa);
        chk("R6 verify ends after mismatching byte", lows, 4);
        chk("R13 irq raised on fault", 32'(irq), 32'd1);
        rd16(4'h7, v); chk("R6 length at stop", 32'(v), 32'd1);
        rd16(4'h2, v); chk("R6 host address at stop", 32'(v), 32'h0303);
        rd(4'h0, s);   chk("R6 status after fault", 32'(s), 32'hE0);
        chk("R13 irq cleared by status read", 32'(irq), 32'd0);
        for (int i = 0; i < 2; i++) xmem[10'hD0 + i] = hmem[10'h310 + i];
        setup(16'h0310, 16'h00D0, 8'h00, 16'd2, 8'h00, 8'h00);
        run("R6", 8'h93, lows, xa);
        chk("R6 matching verify runs full length", lows, 3);
        rd(4'h0, s);   chk("R6 no fault on match", 32'(s), 32'h40);
    endtask

    task automatic t_trigger;
        int lows; logic [23:0] xa; logic [7:0] s;
        setup(16'h0140, 16'h0180, 8'h00, 16'd2, 8'h00, 8'h00);
        wr(4'h1, 8'h80);
        repeat (4) @(negedge clk);
        chk("R7 pending transfer keeps ready high", 32'(cpu_rdy), 32'd1);
        cpu_store(16'h1234);
        repeat (3) @(negedge clk);
        chk("R7 other host store does not start", 32'(cpu_rdy), 32'd1);
        rd(4'h1, s); chk("R7 control still pending", 32'(s), 32'h80);
        cpu_store(16'hFF00);
        chk("R14 ready high in first cycle after trigger", 32'(cpu_rdy), 32'd1);
        wait_done(lows, xa);
        chk("R7 triggered stash ready-low cycles", lows, 3);
        for (int i = 0; i < 2; i++)
            chk("R7 triggered stash byte", 32'(xmem[10'h180 + i]), 32'(hmem[10'h140 + i]));
        rd(4'h1, s); chk("R8 control after triggered start", 32'(s), 32'h10);
    endtask

    task automatic t_hold;
        int lows; logic [23:0] xa; logic [15:0] v;
        setup(16'h0058, 16'h0070, 8'h00, 16'd3, 8'h80, 8'h00);
        run("R9", 8'h90, lows, xa);
        for (int i = 0; i < 3; i++)
            chk("R9 host hold repeats one byte", 32'(xmem[10'h70 + i]), 32'(hmem[10'h58]));
        rd16(4'h2, v); chk("R9 held host address", 32'(v), 32'h0058);
        rd16(4'h4, v); chk("R9 expansion still steps", 32'(v), 32'h0073);
    endtask

    task automatic t_autoload;
        int lows; logic [23:0] xa; logic [15:0] v; logic [7:0] s;
        setup(16'h0040, 16'h0100, 8'h02, 16'd4, 8'h00, 8'hC0);
        run("R12", 8'hB0, lows, xa);
        chk("R9 bank on expansion address", 32'(xa), 32'h020100);
        chk("R13 irq on end of block", 32'(irq), 32'd1);
        rd16(4'h2, v); chk("R12 host base reloaded", 32'(v), 32'h0040);
        rd16(4'h4, v); chk("R12 expansion base reloaded", 32'(v), 32'h0100);
        rd(4'h6, s);   chk("R12 bank reloaded", 32'(s), 32'h02);
        rd16(4'h7, v); chk("R12 length reloaded", 32'(v), 32'd4);
        rd(4'h0, s);   chk("R13 status pending and end-of-block", 32'(s), 32'hC0);
        chk("R13 irq cleared by status read", 32'(irq), 32'd0);
        rd(4'h1, s);   chk("R8 control keeps autoload", 32'(s), 32'h30);
    endtask

    task automatic t_zero;
        int lows; logic [23:0] xa; logic [15:0] v;
        setup(16'h0001, 16'h0002, 8'h00, 16'd0, 8'hC0, 8'h00);
        run("R10", 8'h90, lows, xa);
        chk("R10 zero length moves 65536 bytes", lows, 65537);
        rd16(4'h7, v); chk("R10 length after zero-length run", 32'(v), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            hmem[i] = 8'(i * 7 + 3);
            xmem[i] = 8'(i * 13 + 91);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stash();
        t_fetch();
        t_swap();
        t_verify();
        t_trigger();
        t_hold();
        t_autoload();
        t_zero();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule